// File: doc/BRIEF.md
# Multi-channel interval timer with register access

This block is a bank of independent up-counting interval timers, four by default, placed behind a simple synchronous register bus. Each channel counts pulses on its own tick-enable strobe. A slow pulse train, a millisecond pulse and a microsecond pulse can therefore drive different channels from the same clock. When a channel's count reaches its programmed terminal value, the channel raises a pending flag. From there it either restarts from zero (continuous mode) or stops and returns to idle (one-shot mode). A channel drives its interrupt line while the flag is pending and its interrupt enable is set.

Software controls each channel by writing to command addresses. Start, stop and clear are strobes, and the data written with them does not matter. Separate addresses take the mode bit, the interrupt enable bit and the terminal value. A packed status word reports the run state, the enable indicator, the mode, the interrupt enable and the pending flag. One global clock-request bit gates counting on all channels at once. A typical use runs one channel as a free-running time base and another as a one-shot event source that is re-armed for each deadline.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every irq line is low. Every status word reads 0x01 (idle, continuous, interrupt disabled, nothing pending), every count reads 0, every terminal value reads 0xFFFFFFFF, and the clock-request register at 0x100 reads 0.
- R2: Read data appears on `bus_rdata` in the cycle after the read strobe, and `bus_rdata` is zero in any cycle that follows a cycle without a read strobe.
- R3: Channel n has its window at byte address n*0x40. A write of any data to window offset 0x04 starts the channel, and a write of any data to offset 0x08 stops it. In the status word at offset 0x10, bits [3:0] hold the state (1 = idle, 2 = running) and bit 4 is the enable indicator.
- R4: A running channel adds one to its count (offset 0x14) for each cycle in which its `tick_en` bit is high, but only while bit 0 of the register at 0x100 is set. A stopped channel, or any channel while that bit is clear, holds its count.
- R5: In continuous mode (bit 0 = 0 written to offset 0x0C), a tick that brings the count up to the terminal value (offset 0x18) sets the pending flag (status bit 7) and returns the count to 0. The channel keeps running.
- R6: In one-shot mode (bit 0 = 1 written to offset 0x0C), reaching the terminal value sets the pending flag, clears the enable and returns the state to idle. The count stays at the terminal value. Status bit 5 reads 1 in one-shot mode.
- R7: A terminal value of 1 produces the event on the first tick after the channel is started.
- R8: A write of any data to offset 0x00 clears the count to 0 and returns the channel to idle. It leaves the terminal value, the mode and the interrupt enable unchanged.
- R9: Each channel's `irq` bit is high exactly when its pending flag is set and its interrupt enable (bit 0 written to offset 0x1C, read back as status bit 6) is set.
- R10: A write to offset 0x20 with data bit 7 set clears the pending flag. A write to that offset with bit 7 clear has no effect. If a terminal event happens in the same cycle as an acknowledge, the flag stays set.
- R11: Reads of the write-only offsets (0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20) and of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R12: Channels are independent. Ticks, commands and events on one channel do not change another channel's count, state or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tick_en | input | 4 | Per-channel count strobe |
| irq | output | 4 | Per-channel interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. Its result, including a change on `irq`, is therefore checked at the falling edge that follows. A tick is counted at the edge that samples it, so a count read is issued only after the tick pulse has been removed. Read data is registered: the bench monitor keeps its own one-cycle-delayed copy of the read strobe and compares `bus_rdata` with the oldest queued expectation at the falling edge after that delay. The monitor also confirms that `bus_rdata` returns to zero in a cycle that follows no read.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

   localparam int WIN_LOG2 = 6;

   localparam logic [WIN_LOG2-1:0] OFF_CLR  = 6'h00;
   localparam logic [WIN_LOG2-1:0] OFF_GO   = 6'h04;
   localparam logic [WIN_LOG2-1:0] OFF_HALT = 6'h08;
   localparam logic [WIN_LOG2-1:0] OFF_MODE = 6'h0C;
   localparam logic [WIN_LOG2-1:0] OFF_STAT = 6'h10;
   localparam logic [WIN_LOG2-1:0] OFF_CNT  = 6'h14;
   localparam logic [WIN_LOG2-1:0] OFF_TERM = 6'h18;
   localparam logic [WIN_LOG2-1:0] OFF_IEN  = 6'h1C;
   localparam logic [WIN_LOG2-1:0] OFF_ACK  = 6'h20;

   localparam logic [3:0] ST_IDLE = 4'd1;
   localparam logic [3:0] ST_RUN  = 4'd2;

   localparam int ACK_BIT = 7;

   typedef struct packed {
      logic clr;
      logic go;
      logic halt;
      logic mode_wr;
      logic term_wr;
      logic ien_wr;
      logic ack;
   } ttb_cmd_t;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_STAT,
      RSEL_CNT,
      RSEL_TERM,
      RSEL_CREQ
   } ttb_rsel_e;

endpackage

// File: rtl/ttb_decode.sv
module ttb_decode
   import ttb_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int ADDR_W     = 9,
   parameter int CREQ_ADDR  = 256,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     wr_i,
   input  logic                     rd_i,
   input  logic                     ack_bit_i,
   output ttb_cmd_t [NUM_CH-1:0]    cmd_o,
   output logic                     creq_wr_o,
   output ttb_rsel_e                rsel_o,
   output logic [CH_W-1:0]          rch_o
);

   localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(NUM_CH << WIN_LOG2);
   localparam logic [ADDR_W-1:0] CREQ_LOC = ADDR_W'(CREQ_ADDR);

   logic                in_win;
   logic [CH_W-1:0]     ch_idx;
   logic [WIN_LOG2-1:0] off;

   assign in_win = (addr_i < WIN_END);
   assign ch_idx = addr_i[WIN_LOG2 +: CH_W];
   assign off    = addr_i[WIN_LOG2-1:0];
   assign rch_o  = ch_idx;

   assign creq_wr_o = wr_i && (addr_i == CREQ_LOC);

   always_comb begin
      cmd_o = '0;
      if (wr_i && in_win) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_W'(c)) begin
               case (off)
                  OFF_CLR:  cmd_o[c].clr     = 1'b1;
                  OFF_GO:   cmd_o[c].go      = 1'b1;
                  OFF_HALT: cmd_o[c].halt    = 1'b1;
                  OFF_MODE: cmd_o[c].mode_wr = 1'b1;
                  OFF_TERM: cmd_o[c].term_wr = 1'b1;
                  OFF_IEN:  cmd_o[c].ien_wr  = 1'b1;
                  OFF_ACK:  cmd_o[c].ack     = ack_bit_i;
                  default:  ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rsel_o = RSEL_NONE;
      if (rd_i) begin
         if (in_win) begin
            case (off)
               OFF_STAT: rsel_o = RSEL_STAT;
               OFF_CNT:  rsel_o = RSEL_CNT;
               OFF_TERM: rsel_o = RSEL_TERM;
               default:  rsel_o = RSEL_NONE;
            endcase
         end else if (addr_i == CREQ_LOC) begin
            rsel_o = RSEL_CREQ;
         end
      end
   end

endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
   import ttb_pkg::*;
#(
   parameter int              CNT_W     = 32,
   parameter int              DATA_W    = 32,
   parameter logic [CNT_W-1:0] TERM_INIT = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  ttb_cmd_t          cmd_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              tick_i,
   input  logic              creq_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  term_o,
   output logic [DATA_W-1:0] status_o,
   output logic              irq_o
);

   logic [CNT_W-1:0] cnt_q, term_q, cnt_inc;
   logic             run_q, oneshot_q, ien_q, pend_q;
   logic             step, hit;

   assign step    = run_q && creq_i && tick_i;
   assign cnt_inc = cnt_q + 1'b1;
   assign hit     = step && (cnt_inc == term_q) && !cmd_i.clr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (cmd_i.clr) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         if (step) begin
            if (hit && !oneshot_q) cnt_q <= '0;
            else                   cnt_q <= cnt_inc;
         end
         if (cmd_i.halt)              run_q <= 1'b0;
         else if (cmd_i.go)           run_q <= 1'b1;
         else if (hit && oneshot_q)   run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         term_q    <= TERM_INIT;
         oneshot_q <= 1'b0;
         ien_q     <= 1'b0;
      end else begin
         if (cmd_i.term_wr) term_q    <= wdata_i;
         if (cmd_i.mode_wr) oneshot_q <= wdata_i[0];
         if (cmd_i.ien_wr)  ien_q     <= wdata_i[0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q <= 1'b0;
      else if (hit)       pend_q <= 1'b1;
      else if (cmd_i.ack) pend_q <= 1'b0;
   end

   assign count_o  = cnt_q;
   assign term_o   = term_q;
   assign irq_o    = pend_q && ien_q;
   assign status_o = DATA_W'({pend_q, ien_q, oneshot_q, run_q,
                              (run_q ? ST_RUN : ST_IDLE)});

endmodule

// File: rtl/ttb_rdmux.sv
module ttb_rdmux
   import ttb_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter bit RDATA_REG = 1'b1,
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  ttb_rsel_e                     rsel_i,
   input  logic [CH_W-1:0]               rch_i,
   input  logic [NUM_CH-1:0][DATA_W-1:0] stat_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  term_i,
   input  logic                          creq_i,
   output logic [DATA_W-1:0]             rdata_o
);

   logic [DATA_W-1:0] rd_n;

   always_comb begin
      case (rsel_i)
         RSEL_STAT: rd_n = stat_i[rch_i];
         RSEL_CNT:  rd_n = DATA_W'(cnt_i[rch_i]);
         RSEL_TERM: rd_n = DATA_W'(term_i[rch_i]);
         RSEL_CREQ: rd_n = DATA_W'(creq_i);
         default:   rd_n = '0;
      endcase
   end

   if (RDATA_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rdata_o <= '0;
         else         rdata_o <= rd_n;
      end
   end else begin : g_comb
      assign rdata_o = rd_n;
   end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import ttb_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 9,
   parameter int CREQ_ADDR = 256,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] tick_en,
   output logic [NUM_CH-1:0] irq
);

   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_nch
      $error("NUM_CH must be a power of two");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cntw
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_dataw
      $error("DATA_W must hold the status byte");
   end
   if (ADDR_W < WIN_LOG2 + CH_W || CREQ_ADDR >= (1 << ADDR_W)
       || CREQ_ADDR < (NUM_CH << WIN_LOG2)) begin : g_bad_map
      $error("address map does not fit ADDR_W");
   end

   ttb_cmd_t [NUM_CH-1:0]          cmd_w;
   logic                           creq_wr;
   logic                           clk_on;
   ttb_rsel_e                      rsel;
   logic [CH_W-1:0]                rch;
   logic [NUM_CH-1:0][DATA_W-1:0]  stat_w;
   logic [NUM_CH-1:0][CNT_W-1:0]   cnt_w;
   logic [NUM_CH-1:0][CNT_W-1:0]   term_w;

   ttb_decode #(
      .NUM_CH    (NUM_CH),
      .ADDR_W    (ADDR_W),
      .CREQ_ADDR (CREQ_ADDR)
   ) u_decode (
      .addr_i    (bus_addr),
      .wr_i      (bus_wr),
      .rd_i      (bus_rd),
      .ack_bit_i (bus_wdata[ACK_BIT]),
      .cmd_o     (cmd_w),
      .creq_wr_o (creq_wr),
      .rsel_o    (rsel),
      .rch_o     (rch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       clk_on <= 1'b0;
      else if (creq_wr) clk_on <= bus_wdata[0];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ttb_channel #(
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W)
      ) u_chan (
         .clk_i    (clk),
         .rst_ni   (rst_n),
         .cmd_i    (cmd_w[i]),
         .wdata_i  (bus_wdata[CNT_W-1:0]),
         .tick_i   (tick_en[i]),
         .creq_i   (clk_on),
         .count_o  (cnt_w[i]),
         .term_o   (term_w[i]),
         .status_o (stat_w[i]),
         .irq_o    (irq[i])
      );
   end

   ttb_rdmux #(
      .NUM_CH    (NUM_CH),
      .CNT_W     (CNT_W),
      .DATA_W    (DATA_W),
      .RDATA_REG (RDATA_REG)
   ) u_rdmux (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .rsel_i  (rsel),
      .rch_i   (rch),
      .stat_i  (stat_w),
      .cnt_i   (cnt_w),
      .term_i  (term_w),
      .creq_i  (clk_on),
      .rdata_o (bus_rdata)
   );

endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 9,
   parameter bit RDATA_REG = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic                          bus_wr,
   input logic                          bus_rd,
   input logic [DATA_W-1:0]             bus_wdata,
   input logic [DATA_W-1:0]             bus_rdata,
   input logic [NUM_CH-1:0]             tick_en,
   input logic [NUM_CH-1:0]             irq,
   input logic                          clk_on,
   input logic [NUM_CH-1:0][DATA_W-1:0] stat_w,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_w
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      localparam logic [ADDR_W-1:0] A_GO   = ADDR_W'(i * 64 + 4);
      localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(i * 64 + 8);
      localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(i * 64 + 32);

      a_r3_start_sets_enable: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_GO) |=> stat_w[i][4]);

      a_r3_stop_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_HALT) |=> !stat_w[i][4]);

      a_r4_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_w[i] != $past(cnt_w[i])) |->
            ((cnt_w[i] == $past(cnt_w[i]) + 1'b1) || (cnt_w[i] == '0)));

      a_r4_gate_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
         !clk_on |=> ((cnt_w[i] == $past(cnt_w[i])) || (cnt_w[i] == '0)));

      a_r5_pending_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_w[i][7]) |-> $past(tick_en[i] && clk_on));

      a_r10_pending_cleared_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stat_w[i][7]) |-> $past(bus_wr && bus_addr == A_ACK && bus_wdata[7]));

      a_r9_irq_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> (stat_w[i][7] && stat_w[i][6]));
   end

   if (RDATA_REG) begin : g_rd
      a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> (bus_rdata == '0));
   end

endmodule

bind tick_timer_bank ttb_checker #(
   .NUM_CH    (NUM_CH),
   .CNT_W     (CNT_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .RDATA_REG (RDATA_REG)
) u_ttb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .tick_en   (tick_en),
   .irq       (irq),
   .clk_on    (clk_on),
   .stat_w    (stat_w),
   .cnt_w     (cnt_w)
);

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  tick_en = '0;
   logic [3:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_d = 1'b0;

   always #2 clk = ~clk;

   tick_timer_bank u_tick_timer_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_en   (tick_en),
      .irq       (irq)
   );

   task automatic note(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: one cycle after each read strobe, pop and compare
   always @(posedge clk) rd_d <= bus_rd;

   always @(negedge clk) begin
      if (rd_d) begin
         if (exp_q.size() == 0) begin
            note(bus_rdata, 32'hx, "R2 read with nothing queued");
         end else begin
            note(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_addr = '0;
   endtask

   task automatic tk(input logic [3:0] mask, input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         tick_en = mask;
         @(posedge clk); #1;
         tick_en = '0;
      end
   endtask

   task automatic wr_tick(input logic [8:0] a, input logic [31:0] d, input logic [3:0] mask);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = mask;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; tick_en = '0;
   endtask

   task automatic chk_irq(input logic [3:0] exp, input string tag);
      @(negedge clk);
      note({28'b0, irq}, {28'b0, exp}, tag);
   endtask

   task automatic chk_idle_rdata(input string tag);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      note(bus_rdata, 32'h0, tag);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk_irq(4'b0000, "R1 irq after reset");
      rd(9'h010, 32'h01, "R1 ch0 status");
      rd(9'h014, 32'h0, "R1 ch0 count");
      rd(9'h018, 32'hFFFF_FFFF, "R1 ch0 terminal");
      rd(9'h100, 32'h0, "R1 clock request");
      rd(9'h0D0, 32'h01, "R1 ch3 status");

      // R11 write-only and unmapped reads, unmapped writes
      rd(9'h004, 32'h0, "R11 start addr read");
      rd(9'h00C, 32'h0, "R11 mode addr read");
      rd(9'h01C, 32'h0, "R11 irq enable addr read");
      rd(9'h020, 32'h0, "R11 ack addr read");
      rd(9'h024, 32'h0, "R11 unmapped window read");
      rd(9'h104, 32'h0, "R11 unmapped high read");
      wr(9'h030, 32'hFFFF_FFFF);
      wr(9'h1FC, 32'h1);
      rd(9'h010, 32'h01, "R11 status after unmapped write");
      rd(9'h100, 32'h0, "R11 clock request after unmapped write");

      // R2 idle read data
      chk_idle_rdata("R2 rdata zero without read");

      // R3 and R4 on channel 0
      wr(9'h018, 32'd5);
      wr(9'h004, 32'hDEAD_BEEF);
      rd(9'h010, 32'h12, "R3 status running");
      tk(4'b0001, 3);
      rd(9'h014, 32'd0, "R4 no count without clock request");
      wr(9'h100, 32'h1);
      rd(9'h100, 32'h1, "R4 clock request set");
      tk(4'b0001, 3);
      rd(9'h014, 32'd3, "R4 count after three ticks");
      wr(9'h008, 32'h1234_5678);
      rd(9'h010, 32'h01, "R3 status stopped");
      tk(4'b0001, 2);
      rd(9'h014, 32'd3, "R4 stopped channel holds");

      // R5 continuous terminal event
      wr(9'h004, 32'h0);
      tk(4'b0001, 2);
      rd(9'h014, 32'd0, "R5 count restarts");
      rd(9'h010, 32'h92, "R5 status pending running");
      chk_irq(4'b0000, "R9 pending but interrupt disabled");
      wr(9'h01C, 32'h1);
      chk_irq(4'b0001, "R9 irq after enable");
      rd(9'h010, 32'hD2, "R9 status with irq enable");

      // R10 acknowledge
      wr(9'h020, 32'h7F);
      chk_irq(4'b0001, "R10 ack without bit 7 ignored");
      wr(9'h020, 32'h80);
      chk_irq(4'b0000, "R10 ack clears");
      rd(9'h010, 32'h52, "R10 status after ack");
      tk(4'b0001, 5);
      chk_irq(4'b0001, "R5 second period event");
      rd(9'h014, 32'd0, "R5 count after second period");
      wr(9'h020, 32'h80);
      tk(4'b0001, 4);
      wr_tick(9'h020, 32'h80, 4'b0001);
      chk_irq(4'b0001, "R10 event beats same-cycle ack");
      rd(9'h014, 32'd0, "R10 count after event");
      wr(9'h020, 32'h80);
      chk_irq(4'b0000, "R10 ack after collision");

      // R8 clear command
      tk(4'b0001, 2);
      wr(9'h000, 32'hFFFF_FFFF);
      rd(9'h014, 32'd0, "R8 count cleared");
      rd(9'h010, 32'h41, "R8 idle, settings kept");
      rd(9'h018, 32'd5, "R8 terminal kept");
      tk(4'b0001, 1);
      rd(9'h014, 32'd0, "R8 idle after clear does not count");

      // R6 and R7 one-shot on channel 1
      wr(9'h058, 32'd1);
      wr(9'h04C, 32'h1);
      wr(9'h05C, 32'h1);
      wr(9'h044, 32'h0);
      rd(9'h050, 32'h72, "R6 one-shot running status");
      tk(4'b0010, 1);
      chk_irq(4'b0010, "R7 event on first tick");
      rd(9'h050, 32'hE1, "R6 one-shot back to idle");
      rd(9'h054, 32'd1, "R7 count at terminal");
      tk(4'b0010, 3);
      rd(9'h054, 32'd1, "R6 one-shot holds count");
      rd(9'h04C, 32'h0, "R11 mode not readable");

      // R12 independence
      wr(9'h098, 32'd3);
      wr(9'h084, 32'h0);
      wr(9'h0C4, 32'h0);
      tk(4'b0100, 3);
      rd(9'h094, 32'd0, "R12 ch2 wrapped");
      rd(9'h090, 32'h92, "R12 ch2 pending");
      rd(9'h0D4, 32'd0, "R12 ch3 untouched by ch2 ticks");
      tk(4'b1000, 2);
      rd(9'h0D4, 32'd2, "R12 ch3 counts own ticks");
      rd(9'h094, 32'd0, "R12 ch2 untouched by ch3 ticks");
      rd(9'h014, 32'd0, "R12 ch0 untouched");
      chk_irq(4'b0010, "R12 irq lines separate");

      // R4 global gate off
      wr(9'h100, 32'h0);
      tk(4'b1000, 2);
      rd(9'h0D4, 32'd2, "R4 gate off holds ch3");

      repeat (4) @(posedge clk);
      note(32'(exp_q.size()), 32'd0, "R2 all reads answered");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule